// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block times the strobes of an external memory interface that runs on a fixed 12-clock machine cycle. It produces an address-latch pulse, an active-low code-read strobe, and a select for the high-address port. The select chooses either the high byte of the wide data pointer or the port's own output register. The strobes run free at a fixed ratio to the oscillator clock. During a machine cycle that performs an external data access, the block leaves out specific pulses.

The instruction sequencer supplies a set of per-machine-cycle flags: external code execution, an external data access together with its address width, a code-table read, and a bit that suppresses the address-latch pulse. The block samples these flags at the last clock of each machine cycle and applies them to the whole of the next cycle. This keeps every strobe free of glitches and gives each pulse a fixed width.

Slot numbering: rising edges of `clk` after reset release are numbered from 0, and edge n belongs to slot n mod 12. The outputs change at the edge that follows a slot and show the decode of that slot. The first machine cycle after reset runs with all flags clear.

Top module: `busStrobeGen`

## Requirements
- R1: `addrLatch` is high after the edges of slots 0, 1, 6 and 7, and low after all other slots. This gives two pulses per machine cycle, each two clocks wide.
- R2: When `extCodeExec` is active for a cycle, `codeRdN` is low after the edges of slots 3, 4, 5, 9, 10 and 11. This gives two pulses per cycle, each three clocks wide. When `extCodeExec` is inactive, `codeRdN` stays high.
- R3: The flags are sampled only at the slot 11 edge and govern the next 12 slots. A flag change at any other time has no effect on the current cycle.
- R4: In a cycle with `dataAccCycle` set, the address-latch pulse of slots 0 and 1 is omitted and the pulse of slots 6 and 7 is kept.
- R5: In a cycle with `dataAccCycle` set, both code-read pulses are omitted.
- R6: When `aleOffBit` is 1 and `extCodeExec` is 0, `addrLatch` stays low for the cycle unless `dataAccCycle` or `codeReadCycle` is set. In those two cases the pulses follow R1 and R4.
- R7: When `extCodeExec` is 1, `aleOffBit` has no effect on `addrLatch`.
- R8: `p2HiSel` is 1 (high byte of the wide pointer) for a cycle with `dataAccCycle` set and `dataAccWide`=1. It is 0 (port register) in all other cycles.
- R9: While `rstN` is low, `addrLatch`=0, `codeRdN`=1 and `p2HiSel`=0. After release, the first cycle behaves as if all flags were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extCodeExec | input | 1 | Code is fetched from external memory |
| dataAccCycle | input | 1 | Next machine cycle is an external data access |
| dataAccWide | input | 1 | Data access uses the 16-bit pointer (1) or an 8-bit register (0) |
| codeReadCycle | input | 1 | Next machine cycle is a code-table read |
| aleOffBit | input | 1 | Restricts the address-latch pulse to access cycles |
| addrLatch | output | 1 | Address-latch strobe, active high |
| codeRdN | output | 1 | External code read strobe, active low |
| p2HiSel | output | 1 | High-address port source: 1 pointer high byte, 0 port register |

## Verification
The assertions check the following on every cycle:
- pulse widths (two clocks for the address latch, at least three for the code read);
- wrap of the machine-cycle phase;
- absence of code-read pulses in data-access and internal-execution cycles;
- a quiet address latch while suppression applies;
- the port select following the latched access width.

Only the bench scenarios can show the exact slot positions of each pulse, the dropped first latch pulse, and the override of the suppress bit by external execution. The same holds for the insensitivity of a running cycle to flag changes in mid-cycle. The bench shows these by comparing every output against a slot-counting model over mixed sequences of machine cycles.

// File: rtl/busStrobePkg.sv
package busStrobePkg;

  localparam int NUM_HALVES = 2;

  typedef struct packed {
    logic [NUM_HALVES-1:0] aleWin;
    logic [NUM_HALVES-1:0] rdWin;
    logic                  cycleEnd;
  } strobe_t;

  typedef struct packed {
    logic extCode;
    logic dataAcc;
    logic wideAddr;
    logic codeRead;
    logic aleOff;
  } cycFlags_t;

endpackage

// File: rtl/busStrobeCtrl.sv
module busStrobeCtrl
  import busStrobePkg::*;
#(
  parameter int MC_LEN  = 12,
  parameter int ALE_OFS = 0,
  parameter int ALE_W   = 2,
  parameter int RD_OFS  = 3,
  parameter int RD_W    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strb
);
  localparam int HALF = MC_LEN / 2;
  localparam int PH_W = $clog2(MC_LEN);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_LEN - 1);

  logic [PH_W-1:0]       phase;
  logic [PH_W:0]         phaseX;
  logic [NUM_HALVES-1:0] aleWinV;
  logic [NUM_HALVES-1:0] rdWinV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  assign phaseX = {1'b0, phase};

  // One latch window and one read window per half machine cycle
  generate
    for (genvar k = 0; k < NUM_HALVES; k++) begin : g_half
      localparam logic [PH_W:0] ALE_LO = (PH_W+1)'(k * HALF + ALE_OFS);
      localparam logic [PH_W:0] ALE_HI = (PH_W+1)'(k * HALF + ALE_OFS + ALE_W);
      localparam logic [PH_W:0] RD_LO  = (PH_W+1)'(k * HALF + RD_OFS);
      localparam logic [PH_W:0] RD_HI  = (PH_W+1)'(k * HALF + RD_OFS + RD_W);
      assign aleWinV[k] = (phaseX >= ALE_LO) && (phaseX < ALE_HI);
      assign rdWinV[k]  = (phaseX >= RD_LO)  && (phaseX < RD_HI);
    end
  endgenerate

  assign strb.aleWin   = aleWinV;
  assign strb.rdWin    = rdWinV;
  assign strb.cycleEnd = (phase == LAST_PH);

  // R3: the cycle-end strobe is followed by phase zero
  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.cycleEnd |=> (phase == '0));

  // R1/R2: latch and read windows never overlap
  a_r2_windows_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aleWinV, rdWinV}));

endmodule

// File: rtl/busStrobeData.sv
module busStrobeData
  import busStrobePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  strobe_t   strb,
  input  cycFlags_t reqFlags,
  output logic      addrLatch,
  output logic      codeRdN,
  output logic      p2HiSel
);
  cycFlags_t cur;
  logic aleGate;
  logic aleNext;
  logic rdNext;
  logic hiNext;

  // Flags for a machine cycle are captured at the end of the previous cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cur <= '0;
    else if (strb.cycleEnd) cur <= reqFlags;
  end

  always_comb begin
    aleGate = cur.aleOff && !cur.extCode && !cur.dataAcc && !cur.codeRead;
    aleNext = !aleGate && (strb.aleWin[1] || (strb.aleWin[0] && !cur.dataAcc));
    rdNext  = cur.extCode && !cur.dataAcc && (|strb.rdWin);
    hiNext  = cur.dataAcc && cur.wideAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= 1'b0;
      codeRdN   <= 1'b1;
      p2HiSel   <= 1'b0;
    end else begin
      addrLatch <= aleNext;
      codeRdN   <= !rdNext;
      p2HiSel   <= hiNext;
    end
  end

  // R1: every latch pulse is exactly two clocks wide
  a_r1_ale_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrLatch) |=> addrLatch);
  a_r1_ale_max_width: assert property (@(posedge clk) disable iff (!rstN)
    (addrLatch && $past(addrLatch)) |=> !addrLatch);

  // R2: read pulses last at least three clocks; none when running internally
  a_r2_rd_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(codeRdN) |=> !codeRdN ##1 !codeRdN);
  a_r2_internal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cur.extCode) |-> codeRdN);

  // R5: no code read in a data-access cycle
  a_r5_data_no_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(cur.dataAcc) |-> codeRdN);

  // R6: suppressed latch stays low
  a_r6_latch_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    $past(cur.aleOff && !cur.extCode && !cur.dataAcc && !cur.codeRead) |-> !addrLatch);

  // R8: pointer high byte only for a wide data access
  a_r8_hisel_source: assert property (@(posedge clk) disable iff (!rstN)
    p2HiSel |-> $past(cur.dataAcc && cur.wideAddr));

endmodule

// File: rtl/busStrobeGen.sv
module busStrobeGen
  import busStrobePkg::*;
#(
  parameter int MC_LEN  = 12,
  parameter int ALE_OFS = 0,
  parameter int ALE_W   = 2,
  parameter int RD_OFS  = 3,
  parameter int RD_W    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic extCodeExec,
  input  logic dataAccCycle,
  input  logic dataAccWide,
  input  logic codeReadCycle,
  input  logic aleOffBit,
  output logic addrLatch,
  output logic codeRdN,
  output logic p2HiSel
);
  strobe_t   strb;
  cycFlags_t reqFlags;

  assign reqFlags = '{extCode:  extCodeExec,
                      dataAcc:  dataAccCycle,
                      wideAddr: dataAccWide,
                      codeRead: codeReadCycle,
                      aleOff:   aleOffBit};

  busStrobeCtrl #(
    .MC_LEN(MC_LEN), .ALE_OFS(ALE_OFS), .ALE_W(ALE_W),
    .RD_OFS(RD_OFS), .RD_W(RD_W)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  busStrobeData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqFlags  (reqFlags),
    .addrLatch (addrLatch),
    .codeRdN   (codeRdN),
    .p2HiSel   (p2HiSel)
  );

endmodule

// File: tb/busStrobeGen_tb.sv
`timescale 1ns/1ps
module busStrobeGen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extCodeExec = 0, dataAccCycle = 0, dataAccWide = 0, codeReadCycle = 0, aleOffBit = 0;
  logic addrLatch, codeRdN, p2HiSel;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  string scenTag = "";

  // reference model state
  int mPh = 0;
  bit mExt, mDat, mWide, mCode, mOff;
  bit eAle = 0, eRdN = 1, eHi = 0;

  always #4 clk = ~clk;

  busStrobeGen u_dut (
    .clk(clk), .rstN(rstN),
    .extCodeExec(extCodeExec), .dataAccCycle(dataAccCycle), .dataAccWide(dataAccWide),
    .codeReadCycle(codeReadCycle), .aleOffBit(aleOffBit),
    .addrLatch(addrLatch), .codeRdN(codeRdN), .p2HiSel(p2HiSel)
  );

  always @(posedge clk or negedge rstN) begin
    bit inAle, inRd, gate;
    if (!rstN) begin
      mPh = 0; mExt = 0; mDat = 0; mWide = 0; mCode = 0; mOff = 0;
      eAle = 0; eRdN = 1; eHi = 0;
    end else begin
      inAle = (mPh % 6) < 2;
      inRd  = (mPh % 6) >= 3;
      gate  = mOff && !mExt && !mDat && !mCode;
      eAle  = inAle && !gate && !(mDat && mPh < 6);
      eRdN  = !(inRd && mExt && !mDat);
      eHi   = mDat && mWide;
      if (mPh == 11) begin
        mPh = 0;
        mExt = extCodeExec; mDat = dataAccCycle; mWide = dataAccWide;
        mCode = codeReadCycle; mOff = aleOffBit;
      end else mPh++;
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      check(scenTag != "" ? scenTag : (mDat ? "R4" : (mOff && mExt) ? "R7" : mOff ? "R6" : "R1"),
            addrLatch, eAle, "addrLatch");
      check(scenTag != "" ? scenTag : (mDat ? "R5" : "R2"), codeRdN, eRdN, "codeRdN");
      check(scenTag != "" ? scenTag : "R8", p2HiSel, eHi, "p2HiSel");
    end
  end

  task automatic toBoundary();
    do @(negedge clk); while (mPh != 0);
  endtask

  task automatic runCycles(bit ext, bit dat, bit wide, bit code, bit off, int n);
    toBoundary();
    extCodeExec = ext; dataAccCycle = dat; dataAccWide = wide;
    codeReadCycle = code; aleOffBit = off;
    repeat (12 * n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", addrLatch, 1'b0, "addrLatch in reset");
    check("R9", codeRdN, 1'b1, "codeRdN in reset");
    check("R9", p2HiSel, 1'b0, "p2HiSel in reset");
    extCodeExec = 1; dataAccCycle = 1; dataAccWide = 1;
    rstN = 1'b1;
    running = 1;
    // R9: first cycle after reset runs with flags clear
    scenTag = "R9";
    repeat (12) @(negedge clk);
    scenTag = "";
    runCycles(0, 0, 0, 0, 0, 3);   // R1 free run, internal
    runCycles(1, 0, 0, 0, 0, 3);   // R2 external code
    runCycles(1, 1, 1, 0, 0, 2);   // R4 R5 R8 wide access
    runCycles(1, 1, 0, 0, 0, 2);   // R8 narrow access
    runCycles(1, 0, 0, 0, 0, 1);
    runCycles(0, 0, 0, 0, 1, 3);   // R6 suppressed
    runCycles(0, 1, 1, 0, 1, 2);   // R6 with data access
    runCycles(0, 0, 0, 1, 1, 2);   // R6 with code-table read
    runCycles(1, 0, 0, 0, 1, 3);   // R7 override
    runCycles(1, 1, 1, 0, 1, 2);
    // R3: mid-cycle flag changes ignored
    runCycles(0, 0, 0, 0, 1, 1);
    scenTag = "R3";
    repeat (4) @(negedge clk);
    extCodeExec = 1; dataAccCycle = 1; dataAccWide = 1; aleOffBit = 0;
    repeat (3) @(negedge clk);
    extCodeExec = 0; dataAccCycle = 0; dataAccWide = 0; aleOffBit = 1;
    repeat (30) @(negedge clk);
    scenTag = "";
    runCycles(0, 0, 0, 0, 0, 2);
    // R9: reset mid-run returns to idle state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9", addrLatch, 1'b0, "addrLatch after reset");
    check("R9", codeRdN, 1'b1, "codeRdN after reset");
    check("R9", p2HiSel, 1'b0, "p2HiSel after reset");
    rstN = 1'b1;
    runCycles(1, 0, 0, 0, 0, 2);
    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule